// File: doc/BRIEF.md
# Exception Deactivation Vector Selector

This block sits inside an interrupt controller that keeps two banks of per-exception active bits, one for the secure state and one for the non-secure state. When the processor completes an exception, it raises a one-cycle request carrying the exception number and the security state of the requester. The block decides which active bit must be cleared. It drives a one-hot clear strobe into the matching bank and reports whether the return was legal. It also flags an error when the selected vector is not active or the requested number is out of range, and it asks for a level-sensitive source to be pended again.

In the newer behaviour mode the block guards against a corrupted return. Whenever the raw execution priority is negative, the NMI or the correct HardFault bank is deactivated, whatever number was requested. In the older mode the requested exception is always the one deactivated. The legality check always uses the requested number, even when a different vector is forced. Priority computation and pending arbitration are done outside this block.

Top module: `deact_vec_sel`

## Requirements
- R1: Every result (`done_o`, the clear strobes, the re-pend strobes, `illegal_o`, `err_o`) is registered and appears exactly one clock after the cycle in which `req_i` is high. It lasts one cycle. With no request in the previous cycle, all results are zero, and they are zero after reset.
- R2: A requested number of 1 or less, or of `NUM_EXC` or more, raises `err_o` and clears nothing.
- R3: In the newer mode with a raw priority of -1, HardFault (number 3) is deactivated. The non-secure bank is used when `hf_ns_i` is 1, and the secure bank when it is 0.
- R4: In the newer mode with a raw priority of -2, the non-secure NMI entry (number 2) is deactivated.
- R5: In the newer mode with a raw priority of -3, secure HardFault (number 3) is deactivated.
- R6: When no vector is forced, the requested number is deactivated. The secure bank is used only when `req_sec_i` is 1 and `banked_i[num]` is 1; in every other case the non-secure bank is used.
- R7: In the older mode (`v8_mode_i`=0), the requested exception is deactivated whatever the priority is, including negative values.
- R8: `illegal_o` is raised when `banked_i[num]` is 0 and `tgt_sec_i[num]` differs from `req_sec_i`. Here `num` is the requested number. The selected vector is still cleared.
- R9: If the selected vector's active bit (`act_s_i` or `act_ns_i`) is 0, `err_o` is raised, nothing is cleared, and `illegal_o` stays 0.
- R10: When a vector is cleared and its level bit (`lvl_s_i` or `lvl_ns_i` of the same bank) is 1, the re-pend strobe is set for the same bank and number.
- R11: At most one bit is set across both clear strobe vectors.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Completion request, one cycle |
| req_num_i | input | 8 | Requested exception number |
| req_sec_i | input | 1 | Requester is in the secure state |
| v8_mode_i | input | 1 | Selects newer forced-deactivation behaviour |
| exec_prio_i | input | 9 | Raw execution priority, signed |
| hf_ns_i | input | 1 | NMI and HardFault are routed to the non-secure state |
| banked_i | input | NUM_EXC | Exception has a per-state copy |
| tgt_sec_i | input | NUM_EXC | Non-banked exception targets the secure state |
| act_s_i | input | NUM_EXC | Secure active bits |
| act_ns_i | input | NUM_EXC | Non-secure active bits |
| lvl_s_i | input | NUM_EXC | Secure level source still asserted |
| lvl_ns_i | input | NUM_EXC | Non-secure level source still asserted |
| done_o | output | 1 | Result valid |
| clr_s_o | output | NUM_EXC | Clear strobe, secure bank |
| clr_ns_o | output | NUM_EXC | Clear strobe, non-secure bank |
| repend_s_o | output | NUM_EXC | Re-pend strobe, secure bank |
| repend_ns_o | output | NUM_EXC | Re-pend strobe, non-secure bank |
| illegal_o | output | 1 | Illegal exception return |
| err_o | output | 1 | Vector inactive or number out of range |

## Verification
All results are due one cycle after the request. The request is driven at a falling edge and held for one cycle, and the outputs are captured by the rising edge that follows. The bench then samples them at the next falling edge, which lies in the middle of the only cycle in which they are valid. A quiet cycle follows each table entry, so a result that stays high for a second cycle would show as a non-zero strobe. The back-to-back test checks that each of two adjacent requests lands in its own cycle.

// File: rtl/deact_pkg.sv
package deact_pkg;

    localparam int NUM_W  = 8;
    localparam int PRIO_W = 9;

    typedef logic [NUM_W-1:0]         exc_num_t;
    typedef logic signed [PRIO_W-1:0] prio_t;

    localparam exc_num_t EXC_RESET = 8'd1;
    localparam exc_num_t EXC_NMI   = 8'd2;
    localparam exc_num_t EXC_HARD  = 8'd3;

    typedef enum logic [1:0] {
        PICK_REQUESTED,
        PICK_HARD_ROUTED,
        PICK_NMI_NS,
        PICK_HARD_SEC
    } pick_kind_e;

    typedef struct packed {
        pick_kind_e kind;
        logic       sec;
        exc_num_t   num;
    } vec_sel_t;

    typedef struct packed {
        logic bad_range;
        logic inactive;
        logic clear;
        logic illegal;
        logic repend;
    } verdict_t;

    function automatic pick_kind_e force_kind(input logic newer, input prio_t p);
        pick_kind_e k;
        k = PICK_REQUESTED;
        if (newer) begin
            if (p == prio_t'(-1))      k = PICK_HARD_ROUTED;
            else if (p == prio_t'(-2)) k = PICK_NMI_NS;
            else if (p == prio_t'(-3)) k = PICK_HARD_SEC;
        end
        return k;
    endfunction

endpackage

// File: rtl/deact_vec_pick.sv
module deact_vec_pick
    import deact_pkg::*;
(
    input  exc_num_t req_num_i,
    input  logic     req_sec_i,
    input  logic     req_banked_i,
    input  logic     newer_i,
    input  prio_t    prio_i,
    input  logic     hf_ns_i,
    output vec_sel_t sel_o
);

    pick_kind_e kind;

    always_comb begin
        kind       = force_kind(newer_i, prio_i);
        sel_o.kind = kind;
        case (kind)
            PICK_HARD_ROUTED: begin
                sel_o.sec = ~hf_ns_i;
                sel_o.num = EXC_HARD;
            end
            PICK_NMI_NS: begin
                sel_o.sec = 1'b0;
                sel_o.num = EXC_NMI;
            end
            PICK_HARD_SEC: begin
                sel_o.sec = 1'b1;
                sel_o.num = EXC_HARD;
            end
            default: begin
                sel_o.sec = req_sec_i & req_banked_i;
                sel_o.num = req_num_i;
            end
        endcase
    end

endmodule

// File: rtl/deact_legal_chk.sv
module deact_legal_chk
    import deact_pkg::*;
#(
    parameter int NUM_EXC = 48
) (
    input  vec_sel_t           sel_i,
    input  logic               in_range_i,
    input  logic               req_banked_i,
    input  logic               req_tgt_sec_i,
    input  logic               req_sec_i,
    input  logic [NUM_EXC-1:0] act_s_i,
    input  logic [NUM_EXC-1:0] act_ns_i,
    input  logic [NUM_EXC-1:0] lvl_s_i,
    input  logic [NUM_EXC-1:0] lvl_ns_i,
    output verdict_t           verdict_o
);

    localparam int IDX_W = $clog2(NUM_EXC);

    logic [IDX_W-1:0] sidx;
    logic             sel_active;
    logic             sel_level;

    assign sidx = sel_i.num[IDX_W-1:0];

    always_comb begin
        sel_active = 1'b0;
        sel_level  = 1'b0;
        if (in_range_i) begin
            sel_active = sel_i.sec ? act_s_i[sidx] : act_ns_i[sidx];
            sel_level  = sel_i.sec ? lvl_s_i[sidx] : lvl_ns_i[sidx];
        end
    end

    always_comb begin
        verdict_o.bad_range = ~in_range_i;
        verdict_o.inactive  = in_range_i & ~sel_active;
        verdict_o.clear     = in_range_i & sel_active;
        verdict_o.illegal   = verdict_o.clear & ~req_banked_i &
                              (req_tgt_sec_i != req_sec_i);
        verdict_o.repend    = verdict_o.clear & sel_level;
    end

endmodule

// File: rtl/deact_strobe_gen.sv
module deact_strobe_gen
    import deact_pkg::*;
#(
    parameter int NUM_EXC = 48
) (
    input  vec_sel_t           sel_i,
    input  logic               clr_en_i,
    input  logic               rep_en_i,
    output logic [NUM_EXC-1:0] clr_s_o,
    output logic [NUM_EXC-1:0] clr_ns_o,
    output logic [NUM_EXC-1:0] rep_s_o,
    output logic [NUM_EXC-1:0] rep_ns_o
);

    for (genvar i = 0; i < NUM_EXC; i++) begin : g_dec
        localparam exc_num_t KEY = exc_num_t'(i);
        logic hit;
        assign hit         = (sel_i.num == KEY);
        assign clr_s_o[i]  = clr_en_i & hit &  sel_i.sec;
        assign clr_ns_o[i] = clr_en_i & hit & ~sel_i.sec;
        assign rep_s_o[i]  = rep_en_i & hit &  sel_i.sec;
        assign rep_ns_o[i] = rep_en_i & hit & ~sel_i.sec;
    end

endmodule

// File: rtl/deact_vec_sel.sv
module deact_vec_sel
    import deact_pkg::*;
#(
    parameter int NUM_EXC = 48
) (
    input  logic               clk_i,
    input  logic               rst_i,
    input  logic               req_i,
    input  logic [7:0]         req_num_i,
    input  logic               req_sec_i,
    input  logic               v8_mode_i,
    input  logic signed [8:0]  exec_prio_i,
    input  logic               hf_ns_i,
    input  logic [NUM_EXC-1:0] banked_i,
    input  logic [NUM_EXC-1:0] tgt_sec_i,
    input  logic [NUM_EXC-1:0] act_s_i,
    input  logic [NUM_EXC-1:0] act_ns_i,
    input  logic [NUM_EXC-1:0] lvl_s_i,
    input  logic [NUM_EXC-1:0] lvl_ns_i,
    output logic               done_o,
    output logic [NUM_EXC-1:0] clr_s_o,
    output logic [NUM_EXC-1:0] clr_ns_o,
    output logic [NUM_EXC-1:0] repend_s_o,
    output logic [NUM_EXC-1:0] repend_ns_o,
    output logic               illegal_o,
    output logic               err_o
);

    localparam int       IDX_W   = $clog2(NUM_EXC);
    localparam exc_num_t NUM_LIM = exc_num_t'(NUM_EXC);

    logic             in_range;
    logic [IDX_W-1:0] req_idx;
    logic             req_banked;
    logic             req_tgt_sec;
    vec_sel_t         sel;
    verdict_t         verdict;

    logic [NUM_EXC-1:0] clr_s_d, clr_ns_d, rep_s_d, rep_ns_d;

    assign in_range    = (req_num_i > EXC_RESET) && (req_num_i < NUM_LIM);
    assign req_idx     = req_num_i[IDX_W-1:0];
    assign req_banked  = in_range ? banked_i[req_idx]  : 1'b0;
    assign req_tgt_sec = in_range ? tgt_sec_i[req_idx] : 1'b0;

    deact_vec_pick u_pick (
        .req_num_i    (req_num_i),
        .req_sec_i    (req_sec_i),
        .req_banked_i (req_banked),
        .newer_i      (v8_mode_i),
        .prio_i       (exec_prio_i),
        .hf_ns_i      (hf_ns_i),
        .sel_o        (sel)
    );

    deact_legal_chk #(.NUM_EXC(NUM_EXC)) u_chk (
        .sel_i         (sel),
        .in_range_i    (in_range),
        .req_banked_i  (req_banked),
        .req_tgt_sec_i (req_tgt_sec),
        .req_sec_i     (req_sec_i),
        .act_s_i       (act_s_i),
        .act_ns_i      (act_ns_i),
        .lvl_s_i       (lvl_s_i),
        .lvl_ns_i      (lvl_ns_i),
        .verdict_o     (verdict)
    );

    deact_strobe_gen #(.NUM_EXC(NUM_EXC)) u_strb (
        .sel_i    (sel),
        .clr_en_i (req_i & verdict.clear),
        .rep_en_i (req_i & verdict.repend),
        .clr_s_o  (clr_s_d),
        .clr_ns_o (clr_ns_d),
        .rep_s_o  (rep_s_d),
        .rep_ns_o (rep_ns_d)
    );

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            done_o      <= 1'b0;
            clr_s_o     <= '0;
            clr_ns_o    <= '0;
            repend_s_o  <= '0;
            repend_ns_o <= '0;
            illegal_o   <= 1'b0;
            err_o       <= 1'b0;
        end else begin
            done_o      <= req_i;
            clr_s_o     <= clr_s_d;
            clr_ns_o    <= clr_ns_d;
            repend_s_o  <= rep_s_d;
            repend_ns_o <= rep_ns_d;
            illegal_o   <= req_i & verdict.illegal;
            err_o       <= req_i & (verdict.bad_range | verdict.inactive);
        end
    end

endmodule

// File: rtl/deact_sel_props.sv
module deact_sel_props
    import deact_pkg::*;
#(
    parameter int NUM_EXC = 48
) (
    input logic               clk_i,
    input logic               rst_i,
    input logic               req_i,
    input logic [7:0]         req_num_i,
    input logic               v8_mode_i,
    input logic signed [8:0]  exec_prio_i,
    input logic [NUM_EXC-1:0] act_s_i,
    input logic [NUM_EXC-1:0] act_ns_i,
    input logic               done_o,
    input logic [NUM_EXC-1:0] clr_s_o,
    input logic [NUM_EXC-1:0] clr_ns_o,
    input logic [NUM_EXC-1:0] repend_s_o,
    input logic [NUM_EXC-1:0] repend_ns_o,
    input logic               illegal_o,
    input logic               err_o
);

    localparam exc_num_t NUM_LIM = exc_num_t'(NUM_EXC);

    logic ok_num;
    assign ok_num = (req_num_i > EXC_RESET) && (req_num_i < NUM_LIM);

    AST_DONE_LATENCY: assert property (@(posedge clk_i) disable iff (rst_i)
        req_i |=> done_o); // R1
    AST_QUIET_WITHOUT_REQ: assert property (@(posedge clk_i) disable iff (rst_i)
        !req_i |=> (!done_o && clr_s_o == '0 && clr_ns_o == '0 && !err_o)); // R1
    AST_RANGE_ERR: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && !ok_num) |=> (err_o && clr_s_o == '0 && clr_ns_o == '0)); // R2
    AST_FORCE_NMI: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && ok_num && v8_mode_i && exec_prio_i == -9'sd2 && act_ns_i[2])
        |=> clr_ns_o[2]); // R4
    AST_FORCE_SEC_HARD: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && ok_num && v8_mode_i && exec_prio_i == -9'sd3 && act_s_i[3])
        |=> clr_s_o[3]); // R5
    AST_ILLEGAL_STILL_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
        illegal_o |-> ((clr_s_o | clr_ns_o) != '0)); // R8
    AST_ERR_BLOCKS_CLEAR: assert property (@(posedge clk_i) disable iff (rst_i)
        err_o |-> (clr_s_o == '0 && clr_ns_o == '0 && !illegal_o)); // R9
    AST_REPEND_SUBSET: assert property (@(posedge clk_i) disable iff (rst_i)
        ((repend_s_o & ~clr_s_o) == '0 && (repend_ns_o & ~clr_ns_o) == '0)); // R10
    AST_STROBE_ONEHOT: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({clr_s_o, clr_ns_o})); // R11

endmodule

bind deact_vec_sel deact_sel_props #(.NUM_EXC(NUM_EXC)) u_props (
    .clk_i       (clk_i),
    .rst_i       (rst_i),
    .req_i       (req_i),
    .req_num_i   (req_num_i),
    .v8_mode_i   (v8_mode_i),
    .exec_prio_i (exec_prio_i),
    .act_s_i     (act_s_i),
    .act_ns_i    (act_ns_i),
    .done_o      (done_o),
    .clr_s_o     (clr_s_o),
    .clr_ns_o    (clr_ns_o),
    .repend_s_o  (repend_s_o),
    .repend_ns_o (repend_ns_o),
    .illegal_o   (illegal_o),
    .err_o       (err_o)
);

// File: tb/deact_vec_sel_tb.sv
module deact_vec_sel_tb_top;

    localparam int NE = 48;

    typedef struct packed {
        logic [7:0]        num;
        logic              sec;
        logic              v8;
        logic signed [8:0] prio;
        logic              hfns;
        logic              xclr;
        logic              xbank;
        logic [7:0]        xidx;
        logic              xill;
        logic              xerr;
        logic              xrep;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{8'd17, 1'b0, 1'b0,  9'sd0, 1'b0, 1'b1, 1'b0, 8'd17, 1'b0, 1'b0, 1'b1}, // R6 R10
        '{8'd5,  1'b1, 1'b1,  9'sd4, 1'b0, 1'b1, 1'b1, 8'd5,  1'b0, 1'b0, 1'b1}, // R6 R10
        '{8'd5,  1'b0, 1'b1,  9'sd4, 1'b0, 1'b1, 1'b0, 8'd5,  1'b0, 1'b0, 1'b0}, // R6
        '{8'd16, 1'b1, 1'b1,  9'sd0, 1'b0, 1'b1, 1'b0, 8'd16, 1'b0, 1'b0, 1'b0}, // R6 R8
        '{8'd16, 1'b0, 1'b1,  9'sd0, 1'b0, 1'b1, 1'b0, 8'd16, 1'b1, 1'b0, 1'b0}, // R8
        '{8'd10, 1'b1, 1'b0,  9'sd0, 1'b0, 1'b1, 1'b0, 8'd10, 1'b1, 1'b0, 1'b0}, // R8
        '{8'd10, 1'b0, 1'b1, -9'sd1, 1'b1, 1'b1, 1'b0, 8'd3,  1'b0, 1'b0, 1'b0}, // R3
        '{8'd10, 1'b0, 1'b1, -9'sd1, 1'b0, 1'b1, 1'b1, 8'd3,  1'b0, 1'b0, 1'b0}, // R3
        '{8'd10, 1'b0, 1'b1, -9'sd2, 1'b0, 1'b1, 1'b0, 8'd2,  1'b0, 1'b0, 1'b0}, // R4
        '{8'd10, 1'b0, 1'b1, -9'sd3, 1'b0, 1'b1, 1'b1, 8'd3,  1'b0, 1'b0, 1'b0}, // R5
        '{8'd16, 1'b0, 1'b1, -9'sd3, 1'b0, 1'b1, 1'b1, 8'd3,  1'b1, 1'b0, 1'b0}, // R5 R8
        '{8'd10, 1'b0, 1'b0, -9'sd2, 1'b0, 1'b1, 1'b0, 8'd10, 1'b0, 1'b0, 1'b0}, // R7
        '{8'd20, 1'b0, 1'b1,  9'sd0, 1'b0, 1'b0, 1'b0, 8'd20, 1'b0, 1'b1, 1'b0}, // R9
        '{8'd1,  1'b0, 1'b1,  9'sd0, 1'b0, 1'b0, 1'b0, 8'd1,  1'b0, 1'b1, 1'b0}, // R2
        '{8'd48, 1'b0, 1'b1, -9'sd2, 1'b0, 1'b0, 1'b0, 8'd48, 1'b0, 1'b1, 1'b0}, // R2
        '{8'd47, 1'b0, 1'b1,  9'sd0, 1'b0, 1'b1, 1'b0, 8'd47, 1'b0, 1'b0, 1'b0}  // R2 R6
    };

    logic              clk = 1'b0;
    logic              rst;
    logic              req;
    logic [7:0]        num;
    logic              sec, v8, hfns;
    logic signed [8:0] prio;
    logic [NE-1:0]     banked, tgt, act_s, act_ns, lvl_s, lvl_ns;
    logic              done, ill, err;
    logic [NE-1:0]     clr_s, clr_ns, rep_s, rep_ns;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    deact_vec_sel #(.NUM_EXC(NE)) dut_i (
        .clk_i(clk), .rst_i(rst), .req_i(req), .req_num_i(num),
        .req_sec_i(sec), .v8_mode_i(v8), .exec_prio_i(prio), .hf_ns_i(hfns),
        .banked_i(banked), .tgt_sec_i(tgt), .act_s_i(act_s), .act_ns_i(act_ns),
        .lvl_s_i(lvl_s), .lvl_ns_i(lvl_ns), .done_o(done), .clr_s_o(clr_s),
        .clr_ns_o(clr_ns), .repend_s_o(rep_s), .repend_ns_o(rep_ns),
        .illegal_o(ill), .err_o(err)
    );

    task automatic chk_v(input string tag, input logic [NE-1:0] a, input logic [NE-1:0] e);
        n_checks++;
        if (a !== e) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", tag, a, e);
        end
    endtask

    task automatic chk_b(input string tag, input logic a, input logic e);
        n_checks++;
        if (a !== e) begin
            n_errors++;
            $display("FAIL %s actual=%b expected=%b", tag, a, e);
        end
    endtask

    task automatic drive(input vec_t t);
        num  = t.num;
        sec  = t.sec;
        v8   = t.v8;
        prio = t.prio;
        hfns = t.hfns;
        req  = 1'b1;
    endtask

    task automatic expect_vec(input string tag, input vec_t t);
        logic [NE-1:0] one;
        one = (t.xclr && t.xidx < 8'(NE)) ? (NE'(1) << t.xidx) : '0;
        chk_b({tag, " done R1"}, done, 1'b1);
        chk_v({tag, " clr_s R6"}, clr_s, t.xbank ? one : '0);
        chk_v({tag, " clr_ns R6"}, clr_ns, t.xbank ? '0 : one);
        chk_b({tag, " illegal R8"}, ill, t.xill);
        chk_b({tag, " err R9"}, err, t.xerr);
        chk_v({tag, " repend R10"}, t.xbank ? rep_s : rep_ns, t.xrep ? one : '0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_errors++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
        $finish;
    end

    initial begin
        rst = 1'b1; req = 1'b0; num = '0; sec = 1'b0; v8 = 1'b0;
        prio = '0; hfns = 1'b0;
        banked = '0; banked[6:3] = 4'hF;
        tgt = '0; tgt[16] = 1'b1;
        act_s = '1; act_ns = '1; act_ns[20] = 1'b0;
        lvl_s = '0; lvl_s[5] = 1'b1;
        lvl_ns = '0; lvl_ns[17] = 1'b1;
        repeat (3) @(negedge clk);
        chk_b("reset done R1", done, 1'b0);
        chk_v("reset clr R1", clr_s | clr_ns, '0);
        chk_b("reset err R1", err | ill, 1'b0);
        rst = 1'b0;

        // idle request line with active inputs: nothing may appear (R1)
        num = 8'd10; v8 = 1'b1; prio = -9'sd2;
        @(negedge clk);
        @(negedge clk);
        chk_b("idle done R1", done, 1'b0);
        chk_v("idle clr R1", clr_s | clr_ns, '0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            drive(TBL[i]);
            @(negedge clk);
            req = 1'b0;
            expect_vec($sformatf("vec%0d", i), TBL[i]);
            @(negedge clk);
            chk_v($sformatf("vec%0d one-cycle R1", i), clr_s | clr_ns, '0);
        end

        // forced NMI whose active bit is clear -> error, nothing cleared (R9)
        act_ns[2] = 1'b0;
        @(negedge clk);
        drive('{8'd10, 1'b0, 1'b1, -9'sd2, 1'b0, 1'b0, 1'b0, 8'd2, 1'b0, 1'b1, 1'b0});
        @(negedge clk);
        req = 1'b0;
        chk_b("forced inactive err R9", err, 1'b1);
        chk_v("forced inactive clr R9", clr_s | clr_ns, '0);
        act_ns[2] = 1'b1;

        // forced secure HardFault with level source still high (R10)
        lvl_s[3] = 1'b1;
        @(negedge clk);
        drive('{8'd12, 1'b0, 1'b1, -9'sd3, 1'b0, 1'b1, 1'b1, 8'd3, 1'b0, 1'b0, 1'b1});
        @(negedge clk);
        req = 1'b0;
        chk_v("forced repend_s R10", rep_s, NE'(1) << 3);
        chk_v("forced repend_ns R10", rep_ns, '0);
        lvl_s[3] = 1'b0;

        // back-to-back requests each land in their own cycle (R1 R11)
        @(negedge clk);
        drive(TBL[8]);
        @(negedge clk);
        drive(TBL[9]);
        expect_vec("b2b first", TBL[8]);
        @(negedge clk);
        req = 1'b0;
        expect_vec("b2b second", TBL[9]);
        chk_b("b2b onehot R11", $onehot0({clr_s, clr_ns}), 1'b1);
        @(negedge clk);
        chk_b("b2b trailing done R1", done, 1'b0);

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule